// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block takes the fast input oscillator and splits it into four non-overlapping phases, Q1 to Q4, that together make one instruction cycle. Over those cycles it runs a two-stage pipeline. While the instruction at the current program counter is being fetched from a synchronous program memory, the instruction fetched in the previous cycle sits in the instruction register and is executed. An external execute unit reads the instruction register and the phase outputs. It uses the data-memory read strobe in Q2 and the write strobe in Q4.

When that unit requests a branch, the block handles the pipeline. It samples the request at the close of Q4, loads the target into the program counter at the next Q1, and discards the instruction that was fetched alongside. The following cycle runs as a flushed no-op, with the flush indicator high. The target instruction executes one cycle later. A divided clock output runs at the instruction rate.

Top module: `qphase_sequencer`

## Requirements
- R1: Exactly one of the four phase outputs is high on every clock. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. The phase advances Q1, Q2, Q3, Q4, then back to Q1, one step per input clock. It is Q1 during reset and on the first clock after reset.
- R2: The clock output is high during Q1 and Q2 and low during Q3 and Q4.
- R3: During reset and in the first instruction cycle after it:
  - the fetch address is 0;
  - the instruction register holds the no-op word (default 12'h000);
  - flush is low;
  - neither data-memory strobe is asserted.
- R4: The fetch address stays constant through an instruction cycle. Without a branch it advances by one, modulo 2^ADDR_W, at each Q4-to-Q1 boundary.
- R5: At each Q4-to-Q1 boundary without a branch, the instruction register takes the word on the instruction input during the Q4 clock. It holds that value for the whole next cycle.
- R6: The read strobe is high only in Q2 and the write strobe only in Q4. Both appear only in a valid execute cycle, which is any cycle that is neither the first after reset nor a flush cycle.
- R7: A branch request is acted on only at the clock that ends Q4 of a valid execute cycle. The target address then becomes the fetch address at the next Q1. A request asserted and removed at other phases has no effect.
- R8: In the cycle after a taken branch:
  - flush is high for all four phases;
  - the instruction register holds the no-op word;
  - no data-memory strobe is issued;
  - a branch request is ignored.
- R9: In the cycle after the flush cycle, the instruction register holds the word fetched from the target address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | ADDR_W | Program memory fetch address |
| imem_data | input | INSTR_W | Instruction word returned by program memory |
| br_req | input | 1 | Branch request from the execute unit |
| br_target | input | ADDR_W | Branch target address |
| phase | output | 4 | One-hot phase, bit 0 = Q1 |
| dm_rd | output | 1 | Data-memory operand read strobe |
| dm_wr | output | 1 | Data-memory result write strobe |
| clk_out | output | 1 | Instruction-rate clock output |
| flush | output | 1 | High through a flushed cycle |
| ir_out | output | INSTR_W | Instruction register contents |

## Verification
The embedded assertions check these properties on every clock:
- the phase is one-hot and rotates, and the clock output is tied to it;
- the fetch address and instruction register stay stable away from the Q4 boundary;
- a taken branch loads the target;
- a flush cycle carries the no-op word and issues no strobes;
- the strobes appear only in their own phase.

Some behaviours can only be shown by the bench's scenarios, which compare against a behavioural reference model on every clock:
- a request removed before Q4 is ignored;
- a request held high through flush cycles is ignored there;
- the address wraps at the top of memory;
- the target word reaches the instruction register two cycles after the request;
- a reset in mid-run restores the start-up state.

// File: rtl/qps_pkg.sv
package qps_pkg;
    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } qphase_e;

    localparam int PHASE_CNT = 4;

    typedef struct packed {
        qphase_e ph;
    } phase_state_t;
endpackage

// File: rtl/qps_phase_gen.sv
module qps_phase_gen
    import qps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [PHASE_CNT-1:0] phase_oh,
    output logic                 last_o,
    output logic                 clk_out
);
    phase_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = qphase_e'(st_q.ph + 2'd1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.ph <= PH_Q1;
        else        st_q    <= st_d;
    end

    for (genvar g = 0; g < PHASE_CNT; g++) begin : g_oh
        assign phase_oh[g] = (st_q.ph == qphase_e'(g));
    end

    assign last_o  = (st_q.ph == PH_Q4);
    assign clk_out = ~st_q.ph[1];

    // R1
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_oh) == 1);
    // R1
    phase_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[3] |=> phase_oh[0]);
    // R2
    clk_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out == (phase_oh[0] | phase_oh[1]));
endmodule

// File: rtl/qps_fetch.sv
module qps_fetch #(
    parameter int               ADDR_W  = 9,
    parameter int               INSTR_W = 12,
    parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               last_i,
    input  logic [INSTR_W-1:0] imem_data,
    input  logic               br_req,
    input  logic [ADDR_W-1:0]  br_target,
    output logic [ADDR_W-1:0]  pc_o,
    output logic [INSTR_W-1:0] ir_o,
    output logic               valid_o,
    output logic               flush_o
);
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0]  pc;
        logic [INSTR_W-1:0] ir;
        logic               valid;
        logic               flush;
    } fetch_state_t;

    fetch_state_t st_d, st_q;
    logic         take_br;

    always_comb begin
        st_d    = st_q;
        take_br = last_i && br_req && st_q.valid;
        if (last_i) begin
            if (take_br) begin
                st_d.pc    = br_target;
                st_d.ir    = NOP_WORD;
                st_d.valid = 1'b0;
                st_d.flush = 1'b1;
            end else begin
                st_d.pc    = st_q.pc + PC_STEP;
                st_d.ir    = imem_data;
                st_d.valid = 1'b1;
                st_d.flush = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc    <= '0;
            st_q.ir    <= NOP_WORD;
            st_q.valid <= 1'b0;
            st_q.flush <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o    = st_q.pc;
    assign ir_o    = st_q.ir;
    assign valid_o = st_q.valid;
    assign flush_o = st_q.flush;

    // R4
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(pc_o));
    // R5
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(ir_o));
    // R7
    branch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && br_req && valid_o) |=> (pc_o == $past(br_target)) && flush_o);
    // R8
    flush_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (ir_o == NOP_WORD) && !valid_o);
endmodule

// File: rtl/qps_strobe.sv
module qps_strobe
    import qps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PHASE_CNT-1:0] phase_oh,
    input  logic                 valid_i,
    input  logic                 flush_i,
    output logic                 dm_rd,
    output logic                 dm_wr
);
    always_comb begin
        dm_rd = valid_i && phase_oh[int'(PH_Q2)];
        dm_wr = valid_i && phase_oh[int'(PH_Q4)];
    end

    // R6
    rd_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_rd |-> phase_oh == 4'b0010);
    // R6
    wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_wr |-> phase_oh == 4'b1000);
    // R8
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !dm_rd && !dm_wr);
endmodule

// File: rtl/qphase_sequencer.sv
module qphase_sequencer
    import qps_pkg::*;
#(
    parameter int                 ADDR_W   = 9,
    parameter int                 INSTR_W  = 12,
    parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [ADDR_W-1:0]  imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    input  logic               br_req,
    input  logic [ADDR_W-1:0]  br_target,
    output logic [3:0]         phase,
    output logic               dm_rd,
    output logic               dm_wr,
    output logic               clk_out,
    output logic               flush,
    output logic [INSTR_W-1:0] ir_out
);
    logic [PHASE_CNT-1:0] phase_oh;
    logic                 last_ph;
    logic                 exec_valid;

    qps_phase_gen u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_oh (phase_oh),
        .last_o   (last_ph),
        .clk_out  (clk_out)
    );

    qps_fetch #(
        .ADDR_W   (ADDR_W),
        .INSTR_W  (INSTR_W),
        .NOP_WORD (NOP_WORD)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_i    (last_ph),
        .imem_data (imem_data),
        .br_req    (br_req),
        .br_target (br_target),
        .pc_o      (imem_addr),
        .ir_o      (ir_out),
        .valid_o   (exec_valid),
        .flush_o   (flush)
    );

    qps_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_oh (phase_oh),
        .valid_i  (exec_valid),
        .flush_i  (flush),
        .dm_rd    (dm_rd),
        .dm_wr    (dm_wr)
    );

    assign phase = phase_oh;
endmodule

// File: tb/sim_qphase_sequencer.sv
`timescale 1ns/1ps
module sim_qphase_sequencer;
    localparam int AW = 9;
    localparam int IW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] imem_addr;
    logic [IW-1:0] imem_data = '0;
    logic          br_req = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [3:0]    phase;
    logic          dm_rd, dm_wr, clk_out, flush;
    logic [IW-1:0] ir_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    qphase_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .br_req(br_req), .br_target(br_target), .phase(phase), .dm_rd(dm_rd),
        .dm_wr(dm_wr), .clk_out(clk_out), .flush(flush), .ir_out(ir_out)
    );

    always #5 clk = ~clk;

    function automatic logic [IW-1:0] mem_word(input int a);
        return IW'(a * 37 + 12'h3A5);
    endfunction

    // synchronous program memory: one clock of latency
    always @(posedge clk) imem_data <= mem_word(int'(imem_addr));

    // behavioural reference model
    int            m_ph = 0;
    int            m_pc = 0;
    logic [IW-1:0] m_ir = '0;
    bit            m_val = 0, m_fl = 0, m_first = 1, m_tgt = 0;
    bit            m_took = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pc = 0; m_ir = '0; m_val = 0; m_fl = 0;
            m_first = 1; m_tgt = 0; m_took = 0;
        end else begin
            if (m_ph == 3) begin
                m_tgt   = m_fl;
                m_first = 0;
                if (m_val && br_req) begin
                    m_pc = int'(br_target); m_ir = '0; m_val = 0; m_fl = 1;
                    m_took = 1;
                end else begin
                    m_pc = (m_pc + 1) % (1 << AW); m_ir = imem_data;
                    m_val = 1; m_fl = 0; m_took = 0;
                end
            end
            m_ph = (m_ph + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            string rs;
            rs = (!rst_n || m_first) ? "R3" : "";
            chk(phase == 4'(1 << m_ph), (rs != "") ? rs : "R1", "phase", 32'(phase), 32'(1 << m_ph));
            chk(clk_out == (m_ph < 2), "R2", "clk_out", 32'(clk_out), 32'(m_ph < 2));
            chk(int'(imem_addr) == m_pc, (rs != "") ? rs : (m_took ? "R7" : "R4"),
                "imem_addr", 32'(imem_addr), 32'(m_pc));
            chk(ir_out == m_ir, (rs != "") ? rs : (m_tgt ? "R9" : "R5"), "ir_out",
                32'(ir_out), 32'(m_ir));
            chk(flush == m_fl, (rs != "") ? rs : "R8", "flush", 32'(flush), 32'(m_fl));
            chk(dm_rd == (m_val && m_ph == 1), (rs != "") ? rs : "R6", "dm_rd",
                32'(dm_rd), 32'(m_val && m_ph == 1));
            chk(dm_wr == (m_val && m_ph == 3), (rs != "") ? rs : "R6", "dm_wr",
                32'(dm_wr), 32'(m_val && m_ph == 3));
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic to_phase(input int p);
        while (m_ph != p) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        run(3);                 // R3: reset state sampled while in reset
        rst_n = 1'b1;
        run(32);                // R4 R5 R6: straight-line fetch/execute
        // R7: request raised in Q2 and removed before Q4 is ignored
        to_phase(1); br_req = 1'b1; br_target = 9'h0AA;
        @(negedge clk); br_req = 1'b0;
        run(12);
        // R7 R8 R9: taken branch
        to_phase(3); br_req = 1'b1; br_target = 9'h040;
        @(negedge clk); br_req = 1'b0;
        run(16);
        // R8: request held high, ignored during flush cycles
        to_phase(0); br_req = 1'b1; br_target = 9'h1F0;
        run(24); br_req = 1'b0;
        run(8);
        // R4: wrap at top of address space
        to_phase(3); br_req = 1'b1; br_target = 9'h1FE;
        @(negedge clk); br_req = 1'b0;
        run(20);
        // R3: reset in mid-run
        to_phase(2); rst_n = 1'b0;
        run(3); rst_n = 1'b1;
        run(16);
        finish_run();
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end
endmodule